// File: doc/BRIEF.md
# Headphone Pop-Free Power-Up Sequencer

This controller sequences the start-up of a capacitively coupled headphone driver so that no audible click reaches the load. When a power-on request arrives it captures the configuration and holds the driver in a slow-charge phase. The length of that phase is a number of charging time constants multiplied by a tick count per time constant, and the tick count depends on the selected charge resistor. An offset-calibration phase may follow, depending on a policy field. The signal path is then connected at the heaviest attenuation, and the gain climbs one code per step interval until it reaches the programmed target.

Once the ramp is over the block enters a steady state and raises `done`. From then on, gain changes are applied immediately. Only in this steady state are mute changes and power-off requests taken. All waits count a single-cycle `tick` timebase, so the same logic serves any millisecond scale.

Top module: `hp_popfree_seq`

## Requirements
- R1: After reset `charge_en`, `route_en`, `cal_busy`, `cal_done`, `done` and `tc_clamp` are 0, `gain_code` is 0 and `hp_mute` is 1.
- R2: The charge phase lasts N×T ticks, where T is the tick count per time constant. For `rpop_sel` 00, 01 and 1x, T is TC_TICKS_LO, TC_TICKS_MID and TC_TICKS_HI respectively. For `tc_code` 0–9, N = code/2+1 (integer division). Codes 10, 11, 12, 13, 14 and 15 give N = 6, 7, 8, 16, 24 and 32.
- R3: A resistor select of 1x combined with a `tc_code` of 13 or above is clamped to N=8, and `tc_clamp` reads 1.
- R4: During charge and calibration `route_en` is 0 and `gain_code` is 0.
- R5: The ramp starts from gain code 0 and adds one per interval until it reaches the target. For `step_sel` 01, 10 and 11 the interval is STEP_UNIT, 2×STEP_UNIT and 4×STEP_UNIT ticks. With `step_sel` 00, or a target of 0, the block enters steady state at once with `gain_code` = target.
- R6: In steady state `gain_code` follows `target_gain` directly, with no ramp.
- R7: `done` is 1 only in steady state. `pwr_off_req` is ignored before steady state. `hp_mute` takes the value of `mute_in` only in steady state. Power-off returns `gain_code`, `route_en` and `done` to 0.
- R8: With `cal_mode` 01, every power-up runs a calibration phase of CAL_TICKS ticks with `cal_busy` 1. `cal_done` reads 0 during that phase.
- R9: With `cal_mode` 10, calibration runs only when no calibration has completed since reset. With `cal_mode` 00 or 11, calibration never runs.
- R10: `cal_done` becomes 1 when a calibration phase ends and stays 1 until reset or until the next calibration starts.
- R11: A phase advances only on cycles where `tick` is 1.
- R12: `pwr_on_req` is ignored unless the driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse |
| pwr_on_req | input | 1 | Power-on request |
| pwr_off_req | input | 1 | Power-off request |
| mute_in | input | 1 | Requested mute state |
| rpop_sel | input | 2 | Charge resistor select |
| tc_code | input | 4 | Time-constant count code |
| step_sel | input | 2 | Ramp step interval select |
| cal_mode | input | 2 | Offset-calibration policy |
| target_gain | input | GAIN_W | Programmed gain code |
| charge_en | output | 1 | Slow-charge phase active |
| route_en | output | 1 | Signal routed to driver |
| gain_code | output | GAIN_W | Applied gain code |
| hp_mute | output | 1 | Applied mute state |
| cal_busy | output | 1 | Calibration phase active |
| cal_done | output | 1 | Calibration complete |
| done | output | 1 | Steady state reached |
| tc_clamp | output | 1 | Invalid time-constant code clamped |

## Verification
The bench measures each phase length in ticks against products it computes from the resistor and code tables. This would expose a wrong N decode, a missing clamp for the highest resistor, or an off-by-one in the counters. It follows every ramp sample, so a ramp that starts above zero, skips a code or keeps ramping after steady state would show up. It sends power-off and mute requests mid-sequence and power-on requests in steady state, which catches a design that leaves the sequence early or restarts it. It also power-cycles under each calibration policy: a design that forgets the stored result, or calibrates in the never mode, would produce the wrong phase count.

// File: rtl/hp_popfree_seq.sv
module hp_popfree_seq #(
  parameter int GAIN_W       = 6,
  parameter int TC_TICKS_LO  = 2,
  parameter int TC_TICKS_MID = 5,
  parameter int TC_TICKS_HI  = 12,
  parameter int STEP_UNIT    = 3,
  parameter int CAL_TICKS    = 7,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic              mute_in,
  input  logic [1:0]        rpop_sel,
  input  logic [3:0]        tc_code,
  input  logic [1:0]        step_sel,
  input  logic [1:0]        cal_mode,
  input  logic [GAIN_W-1:0] target_gain,
  output logic              charge_en,
  output logic              route_en,
  output logic [GAIN_W-1:0] gain_code,
  output logic              hp_mute,
  output logic              cal_busy,
  output logic              cal_done,
  output logic              done,
  output logic              tc_clamp
);

  localparam logic [CNT_W-1:0] STEP1 = CNT_W'(STEP_UNIT);
  localparam logic [CNT_W-1:0] STEP2 = CNT_W'(2 * STEP_UNIT);
  localparam logic [CNT_W-1:0] STEP4 = CNT_W'(4 * STEP_UNIT);
  localparam logic [CNT_W-1:0] CAL_LEN = CNT_W'(CAL_TICKS);

  typedef enum logic [2:0] {S_OFF, S_CHARGE, S_CAL, S_RAMP, S_STEADY} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [GAIN_W-1:0] ramp_gain;
  logic [1:0]        rsel_q, step_q, calm_q;
  logic [3:0]        tc_q;
  logic [CNT_W-1:0]  n_raw, n_eff, tc_ticks, charge_len, step_len;
  logic              hi_r, cal_need;
  st_t               route_state;

  assign hi_r = rsel_q[1];
  assign tc_clamp = hi_r && (tc_q >= 4'd13);

  always_comb begin
    case (tc_q)
      4'd10:   n_raw = CNT_W'(6);
      4'd11:   n_raw = CNT_W'(7);
      4'd12:   n_raw = CNT_W'(8);
      4'd13:   n_raw = CNT_W'(16);
      4'd14:   n_raw = CNT_W'(24);
      4'd15:   n_raw = CNT_W'(32);
      default: n_raw = CNT_W'(tc_q >> 1) + CNT_W'(1);
    endcase
  end

  assign n_eff    = tc_clamp ? CNT_W'(8) : n_raw;
  assign tc_ticks = hi_r ? CNT_W'(TC_TICKS_HI) : (rsel_q[0] ? CNT_W'(TC_TICKS_MID) : CNT_W'(TC_TICKS_LO));
  assign charge_len = n_eff * tc_ticks;

  always_comb begin
    case (step_q)
      2'b01:   step_len = STEP1;
      2'b10:   step_len = STEP2;
      default: step_len = STEP4;
    endcase
  end

  assign cal_need    = (calm_q == 2'b01) || ((calm_q == 2'b10) && !cal_done);
  assign route_state = ((step_q == 2'b00) || (target_gain == '0)) ? S_STEADY : S_RAMP;

  assign charge_en = (state == S_CHARGE);
  assign cal_busy  = (state == S_CAL);
  assign done      = (state == S_STEADY);
  assign route_en  = (state == S_RAMP) || (state == S_STEADY);
  assign gain_code = done ? target_gain : ramp_gain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      cnt       <= '0;
      ramp_gain <= '0;
      hp_mute   <= 1'b1;
      cal_done  <= 1'b0;
      rsel_q    <= '0;
      step_q    <= '0;
      calm_q    <= '0;
      tc_q      <= '0;
    end else begin
      case (state)
        S_OFF: begin
          ramp_gain <= '0;
          if (pwr_on_req) begin
            rsel_q <= rpop_sel;
            tc_q   <= tc_code;
            step_q <= step_sel;
            calm_q <= cal_mode;
            cnt    <= '0;
            state  <= S_CHARGE;
          end
        end
        S_CHARGE: if (tick) begin
          if (cnt == charge_len - 1'b1) begin
            cnt <= '0;
            if (cal_need) begin
              cal_done <= 1'b0;
              state    <= S_CAL;
            end else begin
              state <= route_state;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CAL: if (tick) begin
          if (cnt == CAL_LEN - 1'b1) begin
            cnt      <= '0;
            cal_done <= 1'b1;
            state    <= route_state;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RAMP: begin
          if (ramp_gain >= target_gain) begin
            state <= S_STEADY;
          end else if (tick) begin
            if (cnt == step_len - 1'b1) begin
              cnt       <= '0;
              ramp_gain <= ramp_gain + 1'b1;
              if ((ramp_gain + 1'b1) >= target_gain) state <= S_STEADY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_STEADY: begin
          ramp_gain <= '0;
          hp_mute   <= mute_in;
          if (pwr_off_req) state <= S_OFF;
        end
        default: state <= S_OFF;
      endcase
    end
  end

  p_route_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(route_en) && !done) |-> (gain_code == '0));

  p_charge_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (charge_en || cal_busy) |-> (gain_code == '0));

  p_ramp_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en && !done && $past(route_en && !done)) |->
      ((gain_code == $past(gain_code)) || (gain_code == $past(gain_code) + 1'b1)));

  p_off_from_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(route_en) |-> $past(done));

  p_mute_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(hp_mute));

  p_cal_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cal_busy) && (calm_q == 2'b10)) |-> !$past(cal_done));

endmodule

// File: tb/hp_popfree_seq_bench.sv
module hp_popfree_seq_bench;
  localparam int GW = 6;
  localparam int TLO = 2, TMID = 5, THI = 12, SU = 3, CT = 7;

  logic clk = 0, rst_n = 0, tick = 1, pwr_on = 0, pwr_off = 0, mute_in = 1;
  logic [1:0] rpop_sel = 0, step_sel = 0, cal_mode = 0;
  logic [3:0] tc_code = 0;
  logic [GW-1:0] target = 0;
  logic charge_en, route_en, hp_mute, cal_busy, cal_done, done, tc_clamp;
  logic [GW-1:0] gain_code;

  int total = 0, bad = 0, cyc = 0;
  int nchg, ncal, nramp, viol;

  always #2 clk = ~clk;

  hp_popfree_seq #(.GAIN_W(GW), .TC_TICKS_LO(TLO), .TC_TICKS_MID(TMID), .TC_TICKS_HI(THI),
                   .STEP_UNIT(SU), .CAL_TICKS(CT), .CNT_W(16)) u_hp_popfree_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on_req(pwr_on), .pwr_off_req(pwr_off),
    .mute_in(mute_in), .rpop_sel(rpop_sel), .tc_code(tc_code), .step_sel(step_sel),
    .cal_mode(cal_mode), .target_gain(target), .charge_en(charge_en), .route_en(route_en),
    .gain_code(gain_code), .hp_mute(hp_mute), .cal_busy(cal_busy), .cal_done(cal_done),
    .done(done), .tc_clamp(tc_clamp));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input int code, input int rs);
    int n;
    case (code)
      10: n = 6; 11: n = 7; 12: n = 8; 13: n = 16; 14: n = 24; 15: n = 32;
      default: n = code / 2 + 1;
    endcase
    if (rs >= 2 && code >= 13) n = 8;
    return n;
  endfunction

  function automatic int exp_t(input int rs);
    return (rs >= 2) ? THI : (rs == 1 ? TMID : TLO);
  endfunction

  function automatic int exp_step(input int s);
    return (s == 1) ? SU : (s == 2 ? 2 * SU : 4 * SU);
  endfunction

  task automatic do_reset();
    rst_n = 0; tick = 1; pwr_on = 0; pwr_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic power_up(input int hold);
    int last;
    nchg = 0; ncal = 0; nramp = 0; viol = 0; last = -1;
    @(negedge clk) pwr_on = 1;
    @(negedge clk) pwr_on = 0;
    if (hold > 0) begin
      tick = 0;
      for (int i = 0; i < hold; i++) begin
        if (charge_en) nchg++;
        @(negedge clk);
      end
      tick = 1;
    end
    for (int g = 0; g < 5000 && !done; g++) begin
      if (charge_en) nchg++;
      if (cal_busy) begin
        if (ncal == 0 && cal_done) viol++;
        ncal++;
      end
      if ((charge_en || cal_busy) && (route_en || gain_code != 0)) viol++;
      if (route_en && !done) begin
        if (nramp == 0 && gain_code != 0) viol++;
        if (last >= 0 && gain_code != last && gain_code != last + 1) viol++;
        last = gain_code;
        nramp++;
      end
      @(negedge clk);
    end
  endtask

  task automatic power_down();
    @(negedge clk) pwr_off = 1;
    @(negedge clk) pwr_off = 0;
  endtask

  task automatic t_reset();
    chk("R1 charge_en", charge_en, 0);
    chk("R1 route_en", route_en, 0);
    chk("R1 done", done, 0);
    chk("R1 gain", gain_code, 0);
    chk("R1 hp_mute", hp_mute, 1);
    chk("R1 cal", {cal_busy, cal_done, tc_clamp}, 0);
  endtask

  task automatic t_charge(input int rs, input int code);
    rpop_sel = rs; tc_code = code; step_sel = 0; cal_mode = 0; target = 11;
    power_up(0);
    chk("R2 charge length", nchg, exp_n(code, rs) * exp_t(rs));
    chk("R2 done gain", {done, gain_code}, {1'b1, 6'd11});
    chk("R2 tc_clamp low", tc_clamp, 0);
    power_down();
  endtask

  task automatic t_clamp(input int rs, input int code);
    rpop_sel = rs; tc_code = code; step_sel = 0; cal_mode = 0; target = 4;
    power_up(0);
    chk("R3 clamped length", nchg, 8 * THI);
    chk("R3 tc_clamp", tc_clamp, 1);
    power_down();
  endtask

  task automatic t_ramp(input int s, input int tg);
    rpop_sel = 0; tc_code = 2; step_sel = s; cal_mode = 0; target = tg;
    power_up(0);
    chk("R4 silent charge", viol, 0);
    chk("R5 ramp length", nramp, (s == 0) ? 0 : tg * exp_step(s));
    chk("R5 final gain", gain_code, tg);
    power_down();
  endtask

  task automatic t_direct();
    rpop_sel = 1; tc_code = 0; step_sel = 1; target = 3; cal_mode = 0;
    power_up(0);
    @(negedge clk) target = 20;
    @(negedge clk);
    chk("R6 direct up", gain_code, 20);
    target = 2;
    #1;
    chk("R6 direct down", gain_code, 2);
    chk("R6 still done", done, 1);
    power_down();
  endtask

  task automatic t_mute_off();
    rpop_sel = 0; tc_code = 4; step_sel = 1; target = 2; mute_in = 1;
    @(negedge clk) pwr_on = 1;
    @(negedge clk) pwr_on = 0; mute_in = 0; pwr_off = 1;
    @(negedge clk) pwr_off = 0;
    chk("R7 early off ignored", charge_en, 1);
    chk("R7 mute held", hp_mute, 1);
    for (int g = 0; g < 500 && !done; g++) @(negedge clk);
    chk("R7 reached done", done, 1);
    @(negedge clk);
    chk("R7 mute applied", hp_mute, 0);
    power_down();
    chk("R7 off state", {done, route_en, gain_code}, 0);
    mute_in = 1;
    @(negedge clk);
    chk("R7 mute frozen off", hp_mute, 0);
  endtask

  task automatic t_on_ignored();
    rpop_sel = 0; tc_code = 0; step_sel = 0; target = 7;
    power_up(0);
    @(negedge clk) pwr_on = 1;
    @(negedge clk) pwr_on = 0;
    @(negedge clk);
    chk("R12 steady kept", {done, charge_en}, 2'b10);
    chk("R12 gain kept", gain_code, 7);
    power_down();
  endtask

  task automatic t_tick();
    rpop_sel = 1; tc_code = 3; step_sel = 0; target = 1;
    power_up(20);
    chk("R11 tick gating", nchg, 20 + 2 * TMID);
    power_down();
  endtask

  task automatic t_cal();
    do_reset();
    rpop_sel = 0; tc_code = 0; step_sel = 0; target = 1;
    cal_mode = 2'b10;
    power_up(0);
    chk("R9 first cal runs", ncal, CT);
    chk("R10 cal_done set", cal_done, 1);
    power_down();
    power_up(0);
    chk("R9 second cal skipped", ncal, 0);
    chk("R10 cal_done kept", cal_done, 1);
    power_down();
    cal_mode = 2'b00;
    power_up(0);
    chk("R9 never mode", ncal, 0);
    power_down();
    cal_mode = 2'b01;
    power_up(0);
    chk("R8 every cal 1", ncal, CT);
    chk("R8 cal_done low during cal", viol, 0);
    power_down();
    power_up(0);
    chk("R8 every cal 2", ncal, CT);
    chk("R10 done after cal", cal_done, 1);
    power_down();
    do_reset();
    chk("R10 cleared by reset", cal_done, 0);
    cal_mode = 2'b11;
    power_up(0);
    chk("R9 mode 11 never", ncal, 0);
    power_down();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_charge(0, 10);
    t_charge(1, 3);
    t_charge(2, 12);
    t_charge(0, 15);
    t_charge(1, 13);
    t_clamp(2, 13);
    t_clamp(3, 15);
    t_ramp(1, 5);
    t_ramp(2, 3);
    t_ramp(3, 2);
    t_ramp(0, 9);
    t_ramp(1, 0);
    t_direct();
    t_mute_off();
    t_on_ignored();
    t_tick();
    t_cal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule